// File: doc/BRIEF.md
# Event Spatiotemporal Feature Binner

This block turns a stream of decoded, timestamped pixel events into a three-dimensional activity volume. Each event carries an x and a y coordinate in a 320 by 320 field and a timestamp. The block reduces each coordinate to one of 16 cells, so one cell spans 20 pixels on each axis. The timestamp picks one of 16 time slices, whose length is set at run time. The block then adds one to the matching 8-bit counter in a single-port window memory.

The first accepted event of a window opens slice 0 at its own timestamp. The slice index moves forward whenever an event arrives at or past the end of the current slice. Slices that receive no events are still stepped through, one per cycle. When an event falls beyond the end of slice 15, the window is complete. The block raises `window_done` for one cycle, stalls that event, and holds the volume so a downstream reader can fetch it. When the reader acknowledges, the memory is wiped and the stalled event opens the next window.

Top module: `event_binner`

## Requirements
- R1: After reset, `window_done` and `err_count` are 0. The memory is cleared first, so `ev_ready` stays low for at least 4096 cycles, even while `ev_valid` is held high.
- R2: An event at (x, y) with both coordinates below 320 increments the counter at address `bin*256 + floor(y/20)*16 + floor(x/20)`. This holds at every cell boundary (19/20, 39/40, 319).
- R3: Counters saturate: a cell that receives more than 255 events reads 255.
- R4: An event with x ≥ 320 or y ≥ 320 is accepted and discarded. It changes no counter and no slice state. `err_count` rises by one for each such event and stops at its all-ones value.
- R5: The first valid in-range event of a window opens slice 0, with the slice start set to that event's timestamp.
- R6: While (ts − slice start) modulo 2^TSW is at least the duration, the slice index steps up by one and the slice start moves forward by one duration. The event waits (`ev_ready` low) while this happens and is then counted in the resulting slice. Empty slices are skipped this way, and timestamp wraparound is handled.
- R7: An event that would step past slice 15 closes the window. `window_done` is high for exactly one cycle, and that event is not consumed.
- R8: While a window is held, `rd_data` returns the counter at `rd_addr` one cycle later, and `ev_ready` stays low.
- R9: `win_ack` during hold sets every counter to 0 over 4096 cycles. After that, the stalled event is accepted as the first event of the next window.
- R10: Consecutive events to the same cell are all counted, at one event per two cycles.
- R11: A duration of 0 is treated as a duration of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event taken on this edge |
| ev_x | input | 9 | Column coordinate |
| ev_y | input | 9 | Row coordinate |
| ev_ts | input | 32 | Event timestamp |
| bin_dur | input | 32 | Time-slice duration in timestamp units |
| window_done | output | 1 | One-cycle pulse when a window completes |
| win_ack | input | 1 | Reader releases the held window |
| rd_addr | input | 12 | Read address during hold |
| rd_data | output | 8 | Counter value, one cycle after the address |
| err_count | output | 16 | Saturating count of out-of-range events |

## Verification
The first window uses coordinate pairs placed exactly on both sides of the 20-pixel cell edges and at the last pixel. These show whether the reciprocal divide ever rounds into the neighbouring cell. A burst of 300 events to one cell separates saturation from wraparound and from lost increments in back-to-back updates. Timestamps that jump several slices at once, and a second window that starts just before the 32-bit timestamp wraps, show whether empty slices are stepped and whether the elapsed time is computed modulo the width. A third window with a zero duration tells the clamp to one apart from a stuck slice index. Every window is read back in full, which also confirms that the previous window was cleared.

// File: rtl/evbin_pkg.sv
package evbin_pkg;
  typedef enum logic [1:0] {
    ST_CLR  = 2'd0,
    ST_ACC  = 2'd1,
    ST_HOLD = 2'd2
  } bin_state_e;
endpackage

// File: rtl/win_ram.sv
module win_ram #(
  parameter int AW = 12,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/slice_tracker.sv
module slice_tracker #(
  parameter int TSW = 32,
  parameter int NBINS = 16,
  localparam int BB = $clog2(NBINS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           open_win,
  input  logic           step,
  input  logic [TSW-1:0] open_ts,
  input  logic [TSW-1:0] cur_ts,
  input  logic [TSW-1:0] dur,
  output logic           started,
  output logic [BB-1:0]  bin,
  output logic           over,
  output logic           last
);
  logic [TSW-1:0] slice_start;
  logic [TSW-1:0] elapsed;

  always_comb begin
    elapsed = cur_ts - slice_start;
    over    = elapsed >= dur;
    last    = bin == BB'(NBINS - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      started     <= 1'b0;
      bin         <= '0;
      slice_start <= '0;
    end else if (open_win) begin
      started     <= 1'b1;
      bin         <= '0;
      slice_start <= open_ts;
    end else if (step) begin
      bin         <= bin + BB'(1);
      slice_start <= slice_start + dur;
    end
  end

  assert_bin_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart) |=> (bin == $past(bin) + BB'(1)));
  assert_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (open_win && !restart) |=> (started && bin == '0));
endmodule

// File: rtl/event_binner.sv
module event_binner
  import evbin_pkg::*;
#(
  parameter int FIELD = 320,
  parameter int GRID  = 16,
  parameter int NBINS = 16,
  parameter int CRDW  = 9,
  parameter int TSW   = 32,
  parameter int CW    = 8,
  parameter int ERRW  = 16,
  localparam int CELL_PIX = FIELD / GRID,
  localparam int GB       = $clog2(GRID),
  localparam int BB       = $clog2(NBINS),
  localparam int AW       = BB + 2 * GB,
  localparam int DEPTH    = 1 << AW,
  localparam int RSH      = 16,
  localparam int RECIP    = ((1 << RSH) + CELL_PIX - 1) / CELL_PIX
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_valid,
  output logic            ev_ready,
  input  logic [CRDW-1:0] ev_x,
  input  logic [CRDW-1:0] ev_y,
  input  logic [TSW-1:0]  ev_ts,
  input  logic [TSW-1:0]  bin_dur,
  output logic            window_done,
  input  logic            win_ack,
  input  logic [AW-1:0]   rd_addr,
  output logic [CW-1:0]   rd_data,
  output logic [ERRW-1:0] err_count
);
  localparam int PW = CRDW + RSH + 2;
  localparam logic [CRDW-1:0] FIELD_C = CRDW'(FIELD);

  // floor(c / CELL_PIX) through a fixed-point reciprocal
  function automatic logic [GB-1:0] cell_of(input logic [CRDW-1:0] c);
    logic [PW-1:0] p;
    p = PW'(c) * PW'(RECIP);
    return p[RSH +: GB];
  endfunction

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (&v) ? v : v + CW'(1);
  endfunction

  bin_state_e     st;
  logic           wr_ph;
  logic [AW-1:0]  wr_addr;
  logic [AW-1:0]  clr_cnt;
  logic           done_q;
  logic [ERRW-1:0] err_q;

  // named internal events
  logic           ev_bad, in_acc, adv_req, close_evt, bin_step;
  logic           take_good, take_bad, open_win;
  logic [TSW-1:0] dur_eff;
  logic [AW-1:0]  ev_addr;
  logic           trk_started, trk_over, trk_last;
  logic [BB-1:0]  trk_bin;

  logic           ram_en, ram_we;
  logic [AW-1:0]  ram_addr;
  logic [CW-1:0]  ram_wdata, ram_q;

  always_comb begin
    dur_eff   = (bin_dur == '0) ? TSW'(1) : bin_dur;
    ev_bad    = (ev_x >= FIELD_C) || (ev_y >= FIELD_C);
    in_acc    = (st == ST_ACC) && !wr_ph;
    adv_req   = in_acc && ev_valid && !ev_bad && trk_started && trk_over;
    close_evt = adv_req && trk_last;
    bin_step  = adv_req && !trk_last;
    ev_ready  = in_acc && ev_valid && (ev_bad || !(trk_started && trk_over));
    take_good = ev_ready && !ev_bad;
    take_bad  = ev_ready && ev_bad;
    open_win  = take_good && !trk_started;
    ev_addr   = {(trk_started ? trk_bin : BB'(0)), cell_of(ev_y), cell_of(ev_x)};
  end

  slice_tracker #(.TSW(TSW), .NBINS(NBINS)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (st == ST_CLR),
    .open_win(open_win),
    .step    (bin_step),
    .open_ts (ev_ts),
    .cur_ts  (ev_ts),
    .dur     (dur_eff),
    .started (trk_started),
    .bin     (trk_bin),
    .over    (trk_over),
    .last    (trk_last)
  );

  // single port: clear writes, read-modify-write, or reader access
  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = ev_addr;
    ram_wdata = '0;
    unique case (st)
      ST_CLR: begin
        ram_en   = 1'b1;
        ram_we   = 1'b1;
        ram_addr = clr_cnt;
      end
      ST_ACC: begin
        if (wr_ph) begin
          ram_en    = 1'b1;
          ram_we    = 1'b1;
          ram_addr  = wr_addr;
          ram_wdata = sat_inc(ram_q);
        end else begin
          ram_en = take_good;
        end
      end
      ST_HOLD: begin
        ram_en   = 1'b1;
        ram_addr = rd_addr;
      end
      default: ;
    endcase
  end

  win_ram #(.AW(AW), .DW(CW)) u_ram (
    .clk  (clk),
    .en   (ram_en),
    .we   (ram_we),
    .addr (ram_addr),
    .wdata(ram_wdata),
    .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_CLR;
      wr_ph   <= 1'b0;
      wr_addr <= '0;
      clr_cnt <= '0;
      done_q  <= 1'b0;
      err_q   <= '0;
    end else begin
      done_q <= close_evt;
      if (take_bad && !(&err_q)) err_q <= err_q + ERRW'(1);
      unique case (st)
        ST_CLR: begin
          clr_cnt <= clr_cnt + AW'(1);
          if (clr_cnt == AW'(DEPTH - 1)) st <= ST_ACC;
        end
        ST_ACC: begin
          if (wr_ph) begin
            wr_ph <= 1'b0;
          end else if (take_good) begin
            wr_ph   <= 1'b1;
            wr_addr <= ev_addr;
          end
          if (close_evt) st <= ST_HOLD;
        end
        ST_HOLD: begin
          clr_cnt <= '0;
          if (win_ack) st <= ST_CLR;
        end
        default: st <= ST_CLR;
      endcase
    end
  end

  assign window_done = done_q;
  assign rd_data     = ram_q;
  assign err_count   = err_q;

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    window_done |=> !window_done);
  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |-> !ev_ready);
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACC && wr_ph) |-> (ram_wdata != '0));
  assert_err_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_bad && !(&err_q)) |=> (err_count == $past(err_count) + ERRW'(1)));
  assert_clear_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CLR && clr_cnt != AW'(DEPTH - 1)) |=> (st == ST_CLR && !ev_ready));
  assert_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take_good |=> !ev_ready);
endmodule

// File: tb/tb_event_binner.sv
`timescale 1ns/100ps
module tb_event_binner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [8:0]  ev_x = '0, ev_y = '0;
  logic [31:0] ev_ts = '0;
  logic [31:0] bin_dur = 32'd100;
  logic        window_done;
  logic        win_ack = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic [15:0] err_count;

  event_binner dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_x(ev_x), .ev_y(ev_y), .ev_ts(ev_ts), .bin_dur(bin_dur),
    .window_done(window_done), .win_ack(win_ack), .rd_addr(rd_addr),
    .rd_data(rd_data), .err_count(err_count)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int done_seen = 0;
  int m_err = 0;
  bit finished = 1'b0;

  // reference model
  int unsigned exp_mem [4096];
  bit          m_started = 1'b0;
  int          m_bin = 0;
  logic [31:0] m_start = '0;

  // scoreboard
  int    exp_q[$];
  string rd_tag = "";
  logic  rd_req = 1'b0;
  logic  rd_pend = 1'b0;
  logic  done_prev = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(posedge clk) rd_pend <= rd_req;

  always @(negedge clk) begin
    if (rd_pend) begin
      int e;
      e = exp_q.pop_front();
      chk(rd_data == e[7:0], rd_tag, rd_data, e);
    end
    if (window_done) done_seen++;
    if (window_done && done_prev) chk(1'b0, "R7 pulse width", 2, 1);
    done_prev = window_done;
  end

  task automatic readout(input string tag);
    rd_tag = tag;
    for (int a = 0; a < 4096; a++) begin
      @(negedge clk);
      rd_addr = a[11:0];
      rd_req  = 1'b1;
      exp_q.push_back(int'(exp_mem[a]));
    end
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  // drive one event; nd is the duration applied while a closed window is held
  task automatic send(input int x, input int y, input logic [31:0] ts,
                      input logic [31:0] nd, input string tag, output int waited);
    bit bad, closes;
    logic [31:0] d;
    bad = (x >= 320) || (y >= 320);
    closes = 1'b0;
    d = (bin_dur == 0) ? 32'd1 : bin_dur;
    if (!bad && m_started) begin
      while ((ts - m_start) >= d) begin
        if (m_bin == 15) begin closes = 1'b1; break; end
        m_bin++;
        m_start = m_start + d;
      end
    end
    @(negedge clk);
    ev_x = x[8:0]; ev_y = y[8:0]; ev_ts = ts; ev_valid = 1'b1;
    waited = 0;
    if (closes) begin
      int seen;
      seen = 0;
      for (int i = 0; i < 40 && !window_done; i++) @(negedge clk);
      if (window_done) seen = 1;
      chk(seen == 1, "R7 window_done after bin 15", seen, 1);
      chk(ev_ready == 1'b0, "R7 closing event stalled", ev_ready, 0);
      bin_dur = nd;
      readout({tag, " R8 readout"});
      chk(ev_ready == 1'b0, "R8 stall during hold", ev_ready, 0);
      @(negedge clk); win_ack = 1'b1;
      @(negedge clk); win_ack = 1'b0;
      foreach (exp_mem[i]) exp_mem[i] = 0;
      m_started = 1'b0;
    end
    forever begin
      #1;
      if (ev_ready) break;
      waited++;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
    if (closes) chk(waited >= 4096, "R9 clear before next window", waited, 4096);
    if (bad) begin
      if (m_err < 65535) m_err++;
    end else begin
      int a;
      if (!m_started) begin
        m_started = 1'b1; m_start = ts; m_bin = 0;
      end
      a = m_bin * 256 + (y / 20) * 16 + (x / 20);
      if (exp_mem[a] < 255) exp_mem[a]++;
    end
  endtask

  initial begin
    int w;
    foreach (exp_mem[i]) exp_mem[i] = 0;
    repeat (3) @(negedge clk);
    chk(window_done == 1'b0, "R1 reset window_done", window_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(err_count == 0, "R1 reset err_count", err_count, 0);
    chk(ev_ready == 1'b0, "R1 not ready while clearing", ev_ready, 0);
    // window 1: duration 100, opens at 1000
    send(0, 0, 32'd1000, 32'd100, "", w);
    chk(w >= 4094, "R1 initial clear length", w, 4094);
    send(19, 19, 32'd1010, 32'd100, "", w);   // R2 edge of cell 0
    send(20, 0, 32'd1020, 32'd100, "", w);    // R2 first pixel of cell 1
    send(39, 40, 32'd1030, 32'd100, "", w);   // R2 cell (1,2)
    send(319, 319, 32'd1040, 32'd100, "", w); // R2 last cell
    send(300, 160, 32'd1050, 32'd100, "", w);
    send(320, 5, 32'd1060, 32'd100, "", w);   // R4 x out of range
    send(5, 511, 32'd1061, 32'd100, "", w);   // R4 y out of range
    chk(err_count == m_err[15:0], "R4 err_count", err_count, m_err);
    for (int i = 0; i < 300; i++) send(100, 100, 32'd1070, 32'd100, "", w); // R3 R10
    send(50, 50, 32'd1350, 32'd100, "", w);   // R6 skips to bin 3
    send(60, 60, 32'd1499, 32'd100, "", w);   // R6 bin 4
    send(70, 70, 32'd2499, 32'd100, "", w);   // R6 bin 14
    send(320, 320, 32'd9999, 32'd100, "", w); // R4 no slice effect
    chk(err_count == m_err[15:0], "R4 err_count after third", err_count, m_err);
    // close window 1, window 2 opens just before wrap with duration 4
    send(80, 80, 32'hFFFF_FFF0, 32'd4, "R2 R3 R4 R6 R10", w);
    send(1, 1, 32'hFFFF_FFF3, 32'd4, "", w);
    send(2, 2, 32'h0000_0005, 32'd4, "", w);  // R6 wrap, bin 5
    send(3, 3, 32'h0000_002F, 32'd4, "", w);  // bin 15
    // close window 2, window 3 uses duration 0
    send(4, 4, 32'h0000_0030, 32'd0, "R5 R6 R9", w);
    send(5, 5, 32'h0000_0033, 32'd0, "", w);  // R11 bin 3
    send(6, 6, 32'h0000_003F, 32'd0, "", w);  // R11 bin 15
    send(7, 7, 32'h0000_0040, 32'd0, "R11", w);
    chk(done_seen == 3, "R7 window count", done_seen, 3);
    chk(err_count == m_err[15:0], "R4 err_count final", err_count, m_err);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule